// File: doc/BRIEF.md
# Dual-Half Page ECC Engine

This block computes and checks single-error-correcting codes for a 512-byte flash page, handled as two independent 256-byte halves. Page bytes stream through it one per cycle while the enable input is high. A write pass leaves one 3-byte check value per half on the code outputs. A read pass also takes the six stored check bytes that follow the data. It then presents a 32-bit status word with one 16-bit field per half. Each field gives the failing byte offset, the failing bit index and the correctable and uncorrectable flags, so software can flip the bad bit directly.

A rising edge on the enable clears every accumulator. While the enable is low the block is frozen, and the results can be read at leisure. Each half uses a Hamming-style code with 22 parity bits: for every byte-address bit and for every bit-index bit there is one parity over the positions where that bit is 0 and one over the positions where it is 1.

The control path is one state machine with these states:
- `ST_IDLE`: disabled and frozen.
- `ST_DATA`: accumulating page bytes, with the current half held in a select register.
- `ST_STORED`: capturing stored check bytes, read passes only.
- `ST_DONE`: pass complete, further bytes ignored.

Its transitions are:
- enable low sends any state to `ST_IDLE`.
- an enable rise sends any state to `ST_DATA` and flushes.
- the last data byte of the last half goes from `ST_DATA` to `ST_STORED` on a read pass, or to `ST_DONE` on a write pass.
- the sixth stored byte goes from `ST_STORED` to `ST_DONE`.

Top module: `ecc_page_chk`

## Requirements
- R1: On the cycle after a rising edge of `ecc_en`, each code word reads 0x00C00000 and `status_word` reads 0. The same values hold after reset.
- R2: For each half, code bit 2a+1 (a = 0..7) is the XOR of all data bits in bytes whose in-half offset has bit a set, and bit 2a is the same over offsets with bit a clear. Bit 17+2b (b = 0..2) is the XOR of data bits whose bit index has bit b set, and bit 16+2b is the same over indices with bit b clear. Bits 23:22 are 1.
- R3: `code_words[31:0]` holds the half covering page bytes 0..255 and `code_words[63:32]` the half covering bytes 256..511. Bits 31:24 of each word are 0, and each word updates on the cycle after each accepted byte.
- R4: While `ecc_en` is low, bytes are ignored and both outputs hold their values.
- R5: A pass's read/write choice is `ecc_rd` sampled at the enable rise. On a read pass the six bytes after the 512 data bytes are the stored codes: half 0 first, each least significant byte first. `status_word` stays 0 until the sixth is taken and shows the result on the next cycle. A write pass never sets it.
- R6: `status_word[15:0]` reports half 0 and `[31:16]` half 1. Within a field, bits 7:0 are the byte offset, bit 15 is uncorrectable, bit 14 is correctable, bits 10:8 are the bit index and bits 13:11 are 0.
- R7: When the stored and recomputed codes of a half differ in exactly one bit of each of the 11 parity pairs, the field sets only bit 14 and gives the offset and bit index of the single flipped data bit.
- R8: A half whose 22 parity bits match, or differ in exactly one bit (a check-byte error), reports 0. Differences in bits 23:22 are ignored.
- R9: Any other difference reports bit 15 alone, with offset and bit index 0.
- R10: Bytes after the end of a pass (512 on a write, 518 on a read) change nothing.
- R11: Cycles with `byte_vld` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Engine enable; a rise flushes, low freezes |
| ecc_rd | input | 1 | Pass type sampled at the enable rise: 1 read, 0 write |
| byte_vld | input | 1 | `byte_in` carries a page or check byte this cycle |
| byte_in | input | 8 | Streamed byte |
| code_words | output | 64 | Two 32-bit words, one 24-bit code per half |
| status_word | output | 32 | Two 16-bit per-half check results |

## Verification
A wrong byte counter or half select shows up in the code words on the very next accepted byte, because the parity bit that toggles is picked by the byte's offset. The bench compares both code words against its model after every cycle. A slip in the stored-byte capture, or in the move to `ST_STORED`, only appears once the status word goes live, one cycle after the sixth check byte. Targeted flips at offsets 0, 37, 255, 300 and 301 and in the check bytes expose swapped fields or wrong flag decisions there. A freeze or flush fault appears within one cycle of the enable edge.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int HALF_AW    = 8;
    localparam int BYTE_W     = 8;
    localparam int BIT_AW     = $clog2(BYTE_W);
    localparam int LP_W       = 2 * HALF_AW;
    localparam int CP_W       = 2 * BIT_AW;
    localparam int PAR_W      = LP_W + CP_W;
    localparam int CODE_BYTES = (PAR_W + BYTE_W - 1) / BYTE_W;
    localparam int CODE_W     = CODE_BYTES * BYTE_W;
    localparam int HI_W       = 8;
    localparam int STAT_W     = HALF_AW + HI_W;
    localparam int WORD_W     = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_STORED,
        ST_DONE
    } ecc_state_t;
endpackage

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
    import ecc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               upd,
    input  logic [HALF_AW-1:0] addr,
    input  logic [BYTE_W-1:0]  data,
    output logic [CODE_W-1:0]  code
);
    logic [PAR_W-1:0] par_q;
    logic [PAR_W-1:0] flip;
    logic             bpar;

    // toggle mask for one byte: line pairs from the offset, column pairs from bit positions
    always_comb begin
        bpar = ^data;
        flip = '0;
        for (int i = 0; i < HALF_AW; i++) begin
            flip[2*i]   = bpar & ~addr[i];
            flip[2*i+1] = bpar &  addr[i];
        end
        for (int b = 0; b < BIT_AW; b++) begin
            for (int k = 0; k < BYTE_W; k++) begin
                if (((k >> b) & 1) != 0)
                    flip[LP_W+2*b+1] = flip[LP_W+2*b+1] ^ data[k];
                else
                    flip[LP_W+2*b]   = flip[LP_W+2*b] ^ data[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            par_q <= '0;
        else if (clr)
            par_q <= '0;
        else if (upd)
            par_q <= par_q ^ flip;
    end

    assign code = {{(CODE_W-PAR_W){1'b1}}, par_q};
endmodule

// File: rtl/ecc_syn_decode.sv
module ecc_syn_decode
    import ecc_pkg::*;
(
    input  logic [CODE_W-1:0] calc,
    input  logic [CODE_W-1:0] stored,
    output logic [STAT_W-1:0] stat
);
    localparam int PAIRS = PAR_W / 2;

    logic [PAR_W-1:0]   syn;
    logic [PAIRS-1:0]   pv;
    logic [HALF_AW-1:0] off;
    logic [BIT_AW-1:0]  bix;
    logic               cor;
    logic               unc;
    logic               unused_pad;

    assign unused_pad = ^{calc[CODE_W-1:PAR_W], stored[CODE_W-1:PAR_W]};

    always_comb begin
        syn = calc[PAR_W-1:0] ^ stored[PAR_W-1:0];
        for (int i = 0; i < PAIRS; i++)
            pv[i] = syn[2*i] ^ syn[2*i+1];
        for (int a = 0; a < HALF_AW; a++)
            off[a] = syn[2*a+1];
        for (int b = 0; b < BIT_AW; b++)
            bix[b] = syn[LP_W+2*b+1];
        cor  = &pv;
        unc  = !cor && (syn != '0) && !$onehot(syn);
        stat = '0;
        if (cor)
            stat = {1'b0, 1'b1, {(HI_W-2-BIT_AW){1'b0}}, bix, off};
        else if (unc)
            stat[STAT_W-1] = 1'b1;
    end
endmodule

// File: rtl/ecc_page_chk.sv
module ecc_page_chk
    import ecc_pkg::*;
#(
    parameter int HALVES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ecc_en,
    input  logic                     ecc_rd,
    input  logic                     byte_vld,
    input  logic [BYTE_W-1:0]        byte_in,
    output logic [WORD_W*HALVES-1:0] code_words,
    output logic [STAT_W*HALVES-1:0] status_word
);
    localparam int HSEL_W      = (HALVES > 1) ? $clog2(HALVES) : 1;
    localparam int STORED_N    = HALVES * CODE_BYTES;
    localparam int STORED_LAST = STORED_N - 1;
    localparam logic [WORD_W-1:0] EMPTY_WORD =
        {{(WORD_W-CODE_W){1'b0}}, {(CODE_W-PAR_W){1'b1}}, {PAR_W{1'b0}}};

    ecc_state_t                 state_q, state_d;
    logic                       en_q, rd_q, chk_done_q;
    logic [HSEL_W-1:0]          hsel_q;
    logic [HALF_AW-1:0]         cnt_q;
    logic [HALVES*CODE_W-1:0]   stored_q;
    logic [CODE_W-1:0]          code_h [HALVES];
    logic [STAT_W-1:0]          stat_h [HALVES];
    logic                       rise, take, last_byte, last_half;

    assign rise      = ecc_en & ~en_q;
    assign take      = ecc_en & ~rise & byte_vld;
    assign last_byte = (cnt_q == {HALF_AW{1'b1}});
    assign last_half = (hsel_q == HSEL_W'(HALVES-1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!ecc_en)
            state_d = ST_IDLE;
        else if (rise)
            state_d = ST_DATA;
        else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_DATA:   if (byte_vld && last_byte && last_half)
                               state_d = rd_q ? ST_STORED : ST_DONE;
                ST_STORED: if (byte_vld && cnt_q == HALF_AW'(STORED_LAST))
                               state_d = ST_DONE;
                ST_DONE:   state_d = ST_DONE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // position counters, pass type and stored check bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            rd_q       <= 1'b0;
            chk_done_q <= 1'b0;
            hsel_q     <= '0;
            cnt_q      <= '0;
            stored_q   <= '0;
        end else begin
            en_q <= ecc_en;
            if (rise) begin
                rd_q       <= ecc_rd;
                chk_done_q <= 1'b0;
                hsel_q     <= '0;
                cnt_q      <= '0;
            end else if (take) begin
                if (state_q == ST_DATA) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_byte)
                        hsel_q <= last_half ? '0 : hsel_q + 1'b1;
                end else if (state_q == ST_STORED) begin
                    cnt_q <= cnt_q + 1'b1;
                    for (int j = 0; j < STORED_N; j++)
                        if (cnt_q == HALF_AW'(j))
                            stored_q[BYTE_W*j +: BYTE_W] <= byte_in;
                    if (cnt_q == HALF_AW'(STORED_LAST))
                        chk_done_q <= 1'b1;
                end
            end
        end
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        ecc_half_acc u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (rise),
            .upd   (take && state_q == ST_DATA && hsel_q == HSEL_W'(h)),
            .addr  (cnt_q),
            .data  (byte_in),
            .code  (code_h[h])
        );
        ecc_syn_decode u_dec (
            .calc   (code_h[h]),
            .stored (stored_q[h*CODE_W +: CODE_W]),
            .stat   (stat_h[h])
        );

        AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(status_word[STAT_W*h+STAT_W-2 +: 2])); // R6
        AST_UNC_NO_LOC: assert property (@(posedge clk) disable iff (!rst_n)
            status_word[STAT_W*h+STAT_W-1] |-> (status_word[STAT_W*h +: STAT_W-1] == '0)); // R9
    end

    // outputs
    always_comb begin
        for (int h = 0; h < HALVES; h++) begin
            code_words[WORD_W*h +: WORD_W]  = {{(WORD_W-CODE_W){1'b0}}, code_h[h]};
            status_word[STAT_W*h +: STAT_W] = chk_done_q ? stat_h[h] : '0;
        end
    end

    AST_FLUSH_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (code_words == {HALVES{EMPTY_WORD}})); // R1
    AST_FLUSH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (status_word == '0)); // R1
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_en |=> ($stable(code_words) && $stable(status_word))); // R4
    AST_NO_STATUS_MIDPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (status_word == '0)); // R5
    AST_PAST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && ecc_en && !rise) |=> ($stable(code_words) && $stable(status_word))); // R10
    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && !rise && !byte_vld) |=> ($stable(code_words) && $stable(status_word))); // R11
endmodule

// File: tb/ecc_page_chk_tb_top.sv
module ecc_page_chk_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b0;
    logic        ecc_rd = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [63:0] code_words;
    logic [31:0] status_word;

    ecc_page_chk #(.HALVES(2)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ecc_en      (ecc_en),
        .ecc_rd      (ecc_rd),
        .byte_vld    (byte_vld),
        .byte_in     (byte_in),
        .code_words  (code_words),
        .status_word (status_word)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [23:0] m_code [2];
    logic [7:0]  m_stored [6];
    logic [31:0] m_status;
    int          m_cnt;
    bit          m_en, m_rd;
    logic [7:0]  pg [512];
    logic [7:0]  dd [512];
    logic [7:0]  st [6];

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        end
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_half(input logic [23:0] c, input logic [23:0] s);
        logic [21:0] d;
        int ones;
        bit all_pairs;
        logic [15:0] r;
        d = c[21:0] ^ s[21:0];
        ones = 0;
        for (int i = 0; i < 22; i++) if (d[i]) ones++;
        all_pairs = 1'b1;
        for (int i = 0; i < 11; i++) if (d[2*i] == d[2*i+1]) all_pairs = 1'b0;
        r = 16'h0000;
        if (ones <= 1) r = 16'h0000;
        else if (all_pairs) begin
            r[14] = 1'b1;
            for (int b = 0; b < 3; b++) r[8+b] = d[17+2*b];
            for (int a = 0; a < 8; a++) r[a] = d[2*a+1];
        end else r[15] = 1'b1;
        return r;
    endfunction

    task automatic model_byte(input logic [7:0] b);
        int h, a;
        if (!m_en) return;
        if (m_cnt < 512) begin
            h = m_cnt / 256;
            a = m_cnt % 256;
            for (int k = 0; k < 8; k++) begin
                if (b[k]) begin
                    for (int i = 0; i < 8; i++) m_code[h][2*i + ((a >> i) & 1)] ^= 1'b1;
                    for (int j = 0; j < 3; j++) m_code[h][16 + 2*j + ((k >> j) & 1)] ^= 1'b1;
                end
            end
            m_cnt++;
        end else if (m_rd && m_cnt < 518) begin
            m_stored[m_cnt-512] = b;
            m_cnt++;
            if (m_cnt == 518)
                m_status = {ref_half(m_code[1], {m_stored[5], m_stored[4], m_stored[3]}),
                            ref_half(m_code[0], {m_stored[2], m_stored[1], m_stored[0]})};
        end
    endtask

    task automatic compare(input string req);
        check({req, " code"}, code_words, {8'h00, m_code[1], 8'h00, m_code[0]});
        check({req, " status"}, {32'h0, status_word}, {32'h0, m_status});
    endtask

    task automatic put(input logic [7:0] b, input string req);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        model_byte(b);
        compare(req);
    endtask

    task automatic gap(input logic [7:0] b, input string req);
        byte_vld = 1'b0;
        byte_in  = b;
        @(negedge clk);
        compare(req);
    endtask

    task automatic set_en(input bit en, input bit rd, input string req);
        byte_vld = 1'b0;
        ecc_en   = en;
        ecc_rd   = rd;
        @(negedge clk);
        if (en && !m_en) begin
            m_code[0] = 24'hC00000;
            m_code[1] = 24'hC00000;
            m_cnt     = 0;
            m_status  = 32'h0;
            m_rd      = rd;
        end
        m_en = en;
        compare(req);
    endtask

    task automatic run_read(input string req);
        set_en(1'b0, 1'b0, "R4 pre-read");
        set_en(1'b1, 1'b1, "R1 flush read");
        for (int i = 0; i < 512; i++) begin
            put(dd[i], {req, " data"});
            if (i % 131 == 7) gap(8'hC3, "R11 gap");
        end
        for (int j = 0; j < 6; j++) put(st[j], "R5 stored");
        put(8'h99, "R10 past end read");
        put(8'h01, "R10 past end read");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [23:0] wc0, wc1;
        m_code[0] = 24'hC00000;
        m_code[1] = 24'hC00000;
        m_status  = 32'h0;
        m_cnt = 0; m_en = 1'b0; m_rd = 1'b0;
        for (int i = 0; i < 512; i++) pg[i] = 8'((i * 37 + 11) & 8'hFF);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset");

        // write pass
        set_en(1'b1, 1'b0, "R1 flush write");
        for (int i = 0; i < 512; i++) begin
            put(pg[i], "R2 R3 write");
            if (i % 97 == 5) gap(8'h5A, "R11 gap");
        end
        for (int i = 0; i < 3; i++) put(8'hAA, "R10 past end write");
        check("R3 pad", {56'h0, code_words[63:56]}, 64'h0);
        check("R5 write no status", {32'h0, status_word}, 64'h0);
        wc0 = m_code[0];
        wc1 = m_code[1];
        set_en(1'b0, 1'b0, "R4 disable");
        for (int i = 0; i < 4; i++) put(8'h33, "R4 frozen");

        st[0] = wc0[7:0];  st[1] = wc0[15:8];  st[2] = wc0[23:16];
        st[3] = wc1[7:0];  st[4] = wc1[15:8];  st[5] = wc1[23:16];

        // clean read
        dd = pg;
        run_read("R8 clean");
        check("R8 clean literal", {32'h0, status_word}, 64'h0);

        // single flips in both halves
        dd = pg;
        dd[37]  = dd[37]  ^ 8'h20;
        dd[511] = dd[511] ^ 8'h80;
        run_read("R7 single");
        check("R6 R7 literal", {32'h0, status_word}, {32'h0, 32'h47FF4525});
        set_en(1'b0, 1'b0, "R4 hold result");
        for (int i = 0; i < 3; i++) put(8'h7E, "R4 frozen status");

        // offset 0 flip, double error in half 1
        dd = pg;
        dd[0]   = dd[0]   ^ 8'h01;
        dd[300] = dd[300] ^ 8'h02;
        dd[301] = dd[301] ^ 8'h04;
        run_read("R9 double");
        check("R9 literal", {32'h0, status_word}, {32'h0, 32'h80004000});

        // check-byte errors only, and a pad-bit difference
        dd = pg;
        st[0] = st[0] ^ 8'h01;
        st[4] = st[4] ^ 8'h08;
        st[5] = st[5] ^ 8'h80;
        run_read("R8 check-byte");
        check("R8 check-byte literal", {32'h0, status_word}, 64'h0);

        // abort mid-pass, then flush
        set_en(1'b0, 1'b0, "R4 pre-abort");
        set_en(1'b1, 1'b1, "R1 flush");
        for (int i = 0; i < 100; i++) put(pg[i], "R2 partial");
        set_en(1'b0, 1'b0, "R4 abort");
        put(8'hF0, "R4 frozen partial");
        set_en(1'b1, 1'b0, "R1 reflush");
        check("R1 reflush literal", code_words, 64'h00C00000_00C00000);

        summary();
        $finish;
    end
endmodule